// File: doc/BRIEF.md
# Reset and Start-up Sequencer

This block decides how a small microcontroller core comes out of reset and out of its low-power HALT state. It watches a power-on indication, an already-synchronized active-low external reset pin, a watchdog time-out pulse, the core's HALT flag and a HALT wake-up request. From these it drives a cold reset that clears every functional unit, a warm reset that clears only the program counter and stack pointer, and a core-enable that keeps the core stalled while the oscillator settles. It also keeps two status flags that software reads after a restart to find out what happened. One flag marks a watchdog time-out. The other marks that the chip was powered down in HALT.

Every restart begins with a start-up delay of 2^SST_W clocks (1024 by default). A cold reset adds an option-load delay of OPT_LEN clocks after that delay and holds the cold reset output through both delays. A watchdog time-out that arrives while the core is halted gives a warm reset, which lasts for the start-up delay only. A plain wake-up from HALT asserts neither reset. It stalls the core for the start-up delay and then for one dummy cycle before execution resumes. A new reset request during a delay restarts the count. A cold request also turns a pending warm reset or wake-up into a cold reset.

All controls are plain level or pulse pins. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_i` is high, `cold_rst_o`=1, `warm_rst_o`=0, `core_en_o`=0, `to_flag_o`=0 and `pdf_flag_o`=0. The delay counts from the release of `por_i`, and the stall after that release is SST+OPT_LEN cycles.
- R2: A cold reset request stalls the core for exactly SST+OPT_LEN cycles, counted from the first clock edge that sees no further request. `cold_rst_o` stays high for that whole stall and falls in the same cycle that `core_en_o` rises. A pin reset is `rst_pin_n_i`=0. A watchdog reset outside HALT is `wdt_to_i`=1 with `halt_i`=0.
- R3: `wdt_to_i`=1 with `halt_i`=1, and no pin reset, gives a warm reset. `warm_rst_o` is high for exactly SST cycles, `cold_rst_o` stays low, and the core is stalled for SST cycles.
- R4: The flags change as follows. A power-on reset sets TO=0 and PDF=0. A pin reset outside HALT leaves both flags unchanged. A pin reset in HALT sets TO=0 and PDF=1. A watchdog reset outside HALT sets TO=1 and leaves PDF unchanged. A watchdog reset in HALT sets TO=1 and PDF=1.
- R5: When causes arrive in the same cycle, only the highest one acts, for both the reset kind and the flags. Power-on ranks first, the pin reset second and the watchdog last.
- R6: `wake_req_i` with `halt_i`=1 and no reset cause stalls the core for SST+1 cycles and asserts neither reset. `dummy_cyc_o` is high in the last of those cycles only, and both flags are left unchanged.
- R7: A reset request that arrives during a running delay restarts the delay, so the stall is measured from that newer request.
- R8: A cold request during a warm reset turns it into a cold reset. `warm_rst_o` drops, `cold_rst_o` rises on the next cycle, and the stall becomes SST+OPT_LEN cycles.
- R9: `wake_req_i` has no effect while `halt_i`=0. It also has no effect while a delay or dummy cycle is running, so the stall length does not change.
- R10: `cold_rst_o` and `warm_rst_o` are never high together, and `core_en_o` is low whenever either of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_i | input | 1 | Power-on indication, active high, asynchronous |
| rst_pin_n_i | input | 1 | External reset pin, active low, synchronized |
| wdt_to_i | input | 1 | Watchdog time-out pulse |
| halt_i | input | 1 | Core is in HALT |
| wake_req_i | input | 1 | HALT wake-up request |
| cold_rst_o | output | 1 | Reset of all functional units |
| warm_rst_o | output | 1 | Reset of program counter and stack pointer only |
| core_en_o | output | 1 | Core may execute |
| dummy_cyc_o | output | 1 | Dummy cycle after a wake-up delay |
| to_flag_o | output | 1 | Time-out status flag |
| pdf_flag_o | output | 1 | Power-down status flag |

## Verification
The bench keeps the default parameters: a 10-bit start-up count (1024 clocks) and a 16-clock option-load delay. With these values every one of the five reset conditions, plus the plain wake-up, can be run to completion and measured to the exact cycle within the run budget. This means the checks cover the real terminal value of the counter, the hand-off from the start-up delay to the option-load delay, and the SST+OPT_LEN versus SST versus SST+1 stall lengths, rather than scaled-down versions of them.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  // Ordered so that a numerically larger kind wins an upgrade.
  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_WAKE = 2'd1,
    RK_WARM = 2'd2,
    RK_COLD = 2'd3
  } rst_kind_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SST   = 2'd1,
    ST_OPT   = 2'd2,
    ST_DUMMY = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic to_we;
    logic to_val;
    logic pdf_we;
    logic pdf_val;
  } flag_upd_t;

endpackage

// File: rtl/rst_cause_decode.sv
module rst_cause_decode
  import rst_seq_pkg::*;
(
  input  logic      rst_pin_n_i,
  input  logic      wdt_to_i,
  input  logic      halt_i,
  input  logic      wake_req_i,
  input  logic      busy_i,
  output rst_kind_e req_kind_o,
  output flag_upd_t flag_upd_o
);

  // Power-on is handled as the asynchronous reset of the registers, so it
  // outranks everything here. Pin comes before watchdog, which comes before wake.
  always_comb begin
    req_kind_o = RK_NONE;
    flag_upd_o = '0;
    if (!rst_pin_n_i) begin
      req_kind_o = RK_COLD;
      if (halt_i) begin
        flag_upd_o.to_we   = 1'b1;
        flag_upd_o.to_val  = 1'b0;
        flag_upd_o.pdf_we  = 1'b1;
        flag_upd_o.pdf_val = 1'b1;
      end
    end else if (wdt_to_i) begin
      req_kind_o         = halt_i ? RK_WARM : RK_COLD;
      flag_upd_o.to_we   = 1'b1;
      flag_upd_o.to_val  = 1'b1;
      flag_upd_o.pdf_we  = halt_i;
      flag_upd_o.pdf_val = 1'b1;
    end else if (wake_req_i && halt_i && !busy_i) begin
      req_kind_o = RK_WAKE;
    end
  end

endmodule

// File: rtl/rst_flag_regs.sv
module rst_flag_regs
  import rst_seq_pkg::*;
(
  input  logic      clk_i,
  input  logic      por_i,
  input  flag_upd_t upd_i,
  output logic      to_o,
  output logic      pdf_o
);

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      to_o  <= 1'b0;
      pdf_o <= 1'b0;
    end else begin
      if (upd_i.to_we)  to_o  <= upd_i.to_val;
      if (upd_i.pdf_we) pdf_o <= upd_i.pdf_val;
    end
  end

endmodule

// File: rtl/rst_sst_seq.sv
module rst_sst_seq
  import rst_seq_pkg::*;
#(
  parameter int SST_W   = 10,
  parameter int OPT_LEN = 16
) (
  input  logic       clk_i,
  input  logic       por_i,
  input  rst_kind_e  req_kind_i,
  output seq_state_e state_o,
  output rst_kind_e  kind_o
);

  localparam int OPT_W = (OPT_LEN > 1) ? $clog2(OPT_LEN) : 1;
  localparam logic [SST_W-1:0] SST_LAST = {SST_W{1'b1}};
  localparam logic [OPT_W-1:0] OPT_LAST = OPT_W'(OPT_LEN - 1);

  seq_state_e       state_q;
  rst_kind_e        kind_q;
  logic [SST_W-1:0] sst_cnt_q;
  logic [OPT_W-1:0] opt_cnt_q;
  rst_kind_e        merged_kind;

  // A request during a running sequence can only raise the kind.
  always_comb begin
    if (state_q == ST_RUN || req_kind_i > kind_q) merged_kind = req_kind_i;
    else                                          merged_kind = kind_q;
  end

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      state_q   <= ST_SST;
      kind_q    <= RK_COLD;
      sst_cnt_q <= '0;
      opt_cnt_q <= '0;
    end else if (req_kind_i != RK_NONE) begin
      state_q   <= ST_SST;
      kind_q    <= merged_kind;
      sst_cnt_q <= '0;
      opt_cnt_q <= '0;
    end else begin
      case (state_q)
        ST_SST: begin
          if (sst_cnt_q == SST_LAST) begin
            case (kind_q)
              RK_COLD: state_q <= ST_OPT;
              RK_WAKE: state_q <= ST_DUMMY;
              default: state_q <= ST_RUN;
            endcase
          end else begin
            sst_cnt_q <= sst_cnt_q + 1'b1;
          end
        end
        ST_OPT: begin
          if (opt_cnt_q == OPT_LAST) state_q <= ST_RUN;
          else                       opt_cnt_q <= opt_cnt_q + 1'b1;
        end
        ST_DUMMY: state_q <= ST_RUN;
        default:  state_q <= ST_RUN;
      endcase
    end
  end

  assign state_o = state_q;
  assign kind_o  = kind_q;

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int SST_W   = 10,
  parameter int OPT_LEN = 16
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic rst_pin_n_i,
  input  logic wdt_to_i,
  input  logic halt_i,
  input  logic wake_req_i,
  output logic cold_rst_o,
  output logic warm_rst_o,
  output logic core_en_o,
  output logic dummy_cyc_o,
  output logic to_flag_o,
  output logic pdf_flag_o
);

  rst_kind_e  req_kind;
  rst_kind_e  cur_kind;
  seq_state_e cur_state;
  flag_upd_t  flag_upd;
  logic       busy;

  assign busy = (cur_state != ST_RUN);

  rst_cause_decode u_decode (
    .rst_pin_n_i (rst_pin_n_i),
    .wdt_to_i    (wdt_to_i),
    .halt_i      (halt_i),
    .wake_req_i  (wake_req_i),
    .busy_i      (busy),
    .req_kind_o  (req_kind),
    .flag_upd_o  (flag_upd)
  );

  rst_flag_regs u_flags (
    .clk_i (clk_i),
    .por_i (por_i),
    .upd_i (flag_upd),
    .to_o  (to_flag_o),
    .pdf_o (pdf_flag_o)
  );

  rst_sst_seq #(
    .SST_W   (SST_W),
    .OPT_LEN (OPT_LEN)
  ) u_seq (
    .clk_i      (clk_i),
    .por_i      (por_i),
    .req_kind_i (req_kind),
    .state_o    (cur_state),
    .kind_o     (cur_kind)
  );

  assign core_en_o   = (cur_state == ST_RUN);
  assign dummy_cyc_o = (cur_state == ST_DUMMY);
  assign cold_rst_o  = (cur_kind == RK_COLD) &&
                       (cur_state == ST_SST || cur_state == ST_OPT);
  assign warm_rst_o  = (cur_kind == RK_WARM) && (cur_state == ST_SST);

endmodule

// File: rtl/rst_seq_ctrl_chk.sv
module rst_seq_ctrl_chk (
  input logic clk_i,
  input logic por_i,
  input logic rst_pin_n_i,
  input logic wdt_to_i,
  input logic halt_i,
  input logic wake_req_i,
  input logic cold_rst_o,
  input logic warm_rst_o,
  input logic core_en_o,
  input logic dummy_cyc_o,
  input logic to_flag_o,
  input logic pdf_flag_o
);

  AST_RST_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (por_i)
    !(cold_rst_o && warm_rst_o)); // R10

  AST_CORE_HELD: assert property (@(posedge clk_i) disable iff (por_i)
    (cold_rst_o || warm_rst_o) |-> !core_en_o); // R10

  AST_EN_AFTER_DELAY: assert property (@(posedge clk_i) disable iff (por_i)
    $rose(core_en_o) |-> $past(cold_rst_o || warm_rst_o || dummy_cyc_o)); // R2

  AST_PIN_COLD: assert property (@(posedge clk_i) disable iff (por_i)
    !rst_pin_n_i |=> (cold_rst_o && !warm_rst_o)); // R2

  AST_WDT_HALT_WARM: assert property (@(posedge clk_i) disable iff (por_i)
    (wdt_to_i && halt_i && rst_pin_n_i && core_en_o) |=> (warm_rst_o && !cold_rst_o)); // R3

  AST_TO_ON_WDT: assert property (@(posedge clk_i) disable iff (por_i)
    (wdt_to_i && rst_pin_n_i) |=> to_flag_o); // R4

  AST_PIN_HALT_FLAGS: assert property (@(posedge clk_i) disable iff (por_i)
    (!rst_pin_n_i && halt_i) |=> (!to_flag_o && pdf_flag_o)); // R4

  AST_DUMMY_SINGLE: assert property (@(posedge clk_i) disable iff (por_i)
    dummy_cyc_o |=> !dummy_cyc_o); // R6

  AST_WAKE_NO_HALT: assert property (@(posedge clk_i) disable iff (por_i)
    (wake_req_i && !halt_i && rst_pin_n_i && !wdt_to_i && core_en_o) |=> core_en_o); // R9

endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk chk_i (.*);

// File: tb/rst_seq_ctrl_tb_top.sv
module rst_seq_ctrl_tb_top;

  localparam int SST   = 1024;
  localparam int OPT   = 16;
  localparam int NVEC  = 9;
  localparam int LIMIT = 5000;

  // {pin, wdt, halt, wake, kind[1:0], to, pdf}; kind 0 none, 1 cold, 2 warm, 3 wake
  localparam logic [7:0] VEC [NVEC] = '{
    8'b01000110,  // wdt normal: cold, TO=1 PDF kept 0
    8'b00111110,  // wake in HALT: flags kept
    8'b01101011,  // wdt in HALT: warm, TO=1 PDF=1
    8'b10000111,  // pin normal: cold, flags kept
    8'b10100101,  // pin in HALT: cold, TO=0 PDF=1
    8'b11000101,  // pin+wdt normal: pin wins, flags kept
    8'b01000111,  // wdt normal: TO=1, PDF kept
    8'b11100101,  // pin+wdt in HALT: pin wins, cold
    8'b00010001   // wake without HALT: ignored
  };

  logic clk = 1'b0;
  logic por = 1'b1;
  logic rst_pin_n = 1'b1;
  logic wdt_to = 1'b0;
  logic halt = 1'b0;
  logic wake_req = 1'b0;
  logic cold_rst, warm_rst, core_en, dummy_cyc, to_flag, pdf_flag;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rst_seq_ctrl #(.SST_W(10), .OPT_LEN(OPT)) dut_i (
    .clk_i       (clk),
    .por_i       (por),
    .rst_pin_n_i (rst_pin_n),
    .wdt_to_i    (wdt_to),
    .halt_i      (halt),
    .wake_req_i  (wake_req),
    .cold_rst_o  (cold_rst),
    .warm_rst_o  (warm_rst),
    .core_en_o   (core_en),
    .dummy_cyc_o (dummy_cyc),
    .to_flag_o   (to_flag),
    .pdf_flag_o  (pdf_flag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse(input bit pin, input bit wdt, input bit hlt, input bit wk);
    @(negedge clk);
    rst_pin_n = ~pin;
    wdt_to    = wdt;
    halt      = hlt;
    wake_req  = wk;
    @(negedge clk);
    rst_pin_n = 1'b1;
    wdt_to    = 1'b0;
    halt      = 1'b0;
    wake_req  = 1'b0;
  endtask

  // Counts the cycles with core_en low from the current sample point.
  task automatic measure(output int low, output int n_cold, output int n_warm,
                         output int n_dummy, output int n_both);
    low = 0; n_cold = 0; n_warm = 0; n_dummy = 0; n_both = 0;
    while (!core_en && low < LIMIT) begin
      low++;
      if (cold_rst) n_cold++;
      if (warm_rst) n_warm++;
      if (dummy_cyc) n_dummy++;
      if (cold_rst && warm_rst) n_both++;
      @(negedge clk);
    end
  endtask

  task automatic expect_cold(input string req);
    int low, nc, nw, nd, nb;
    measure(low, nc, nw, nd, nb);
    check(low == SST + OPT, req, "cold stall", low, SST + OPT);
    check(nc == SST + OPT && nw == 0, req, "cold_rst cycles", nc, SST + OPT);
    check(nb == 0, "R10", "both resets high", nb, 0);
  endtask

  initial begin
    int low, nc, nw, nd, nb, exp_low;
    logic [7:0] v;

    // R1: reset state while power-on is held
    repeat (4) @(negedge clk);
    check(cold_rst == 1'b1 && warm_rst == 1'b0, "R1", "cold during por", cold_rst, 1);
    check(core_en == 1'b0, "R1", "core_en during por", core_en, 0);
    check(to_flag == 1'b0 && pdf_flag == 1'b0, "R1", "flags during por",
          {to_flag, pdf_flag}, 0);
    por = 1'b0;
    expect_cold("R1");

    // Table of single-cause vectors
    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      pulse(v[7], v[6], v[5], v[4]);
      measure(low, nc, nw, nd, nb);
      case (v[3:2])
        2'd1:    exp_low = SST + OPT;
        2'd2:    exp_low = SST;
        2'd3:    exp_low = SST + 1;
        default: exp_low = 0;
      endcase
      check(low == exp_low, "R2/R3/R6/R9", $sformatf("row %0d stall", i), low, exp_low);
      check(nc == ((v[3:2] == 2'd1) ? exp_low : 0), "R2", $sformatf("row %0d cold", i),
            nc, (v[3:2] == 2'd1) ? exp_low : 0);
      check(nw == ((v[3:2] == 2'd2) ? exp_low : 0), "R3", $sformatf("row %0d warm", i),
            nw, (v[3:2] == 2'd2) ? exp_low : 0);
      check(nd == ((v[3:2] == 2'd3) ? 1 : 0), "R6", $sformatf("row %0d dummy", i),
            nd, (v[3:2] == 2'd3) ? 1 : 0);
      check(nb == 0, "R10", $sformatf("row %0d both", i), nb, 0);
      check(to_flag == v[1], "R4 R5", $sformatf("row %0d TO", i), to_flag, v[1]);
      check(pdf_flag == v[0], "R4 R5", $sformatf("row %0d PDF", i), pdf_flag, v[0]);
    end

    // R7: a pin reset in the middle of a watchdog delay restarts the count
    pulse(1'b0, 1'b1, 1'b0, 1'b0);
    repeat (500) @(negedge clk);
    pulse(1'b1, 1'b0, 1'b0, 1'b0);
    expect_cold("R7");

    // R9: a wake request during a running wake delay does not restart it
    pulse(1'b0, 1'b0, 1'b1, 1'b1);
    low = 0;
    while (!core_en && low < LIMIT) begin
      low++;
      wake_req = (low == 300);
      halt     = (low == 300);
      @(negedge clk);
    end
    wake_req = 1'b0;
    halt     = 1'b0;
    check(low == SST + 1, "R9", "wake during delay", low, SST + 1);

    // R8: warm reset upgraded by a pin reset
    pulse(1'b0, 1'b1, 1'b1, 1'b0);
    repeat (100) @(negedge clk);
    check(warm_rst == 1'b1 && cold_rst == 1'b0, "R8", "warm before upgrade", warm_rst, 1);
    pulse(1'b1, 1'b0, 1'b0, 1'b0);
    check(cold_rst == 1'b1 && warm_rst == 1'b0, "R8", "cold after upgrade", cold_rst, 1);
    expect_cold("R8");
    check(to_flag == 1'b1 && pdf_flag == 1'b1, "R8", "flags after upgrade",
          {to_flag, pdf_flag}, 3);

    // R5: power-on outranks pin and watchdog in the same cycle
    @(negedge clk);
    por = 1'b1; rst_pin_n = 1'b0; wdt_to = 1'b1; halt = 1'b1;
    @(negedge clk);
    por = 1'b0; rst_pin_n = 1'b1; wdt_to = 1'b0; halt = 1'b0;
    check(to_flag == 1'b0 && pdf_flag == 1'b0, "R5", "flags por priority",
          {to_flag, pdf_flag}, 0);
    expect_cold("R5");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule